// File: doc/BRIEF.md
# Segmented Speculative-Carry Adder

This block is a purely combinational two's-complement adder/subtractor whose
width and internal segment width are parameters. The operands are cut into
equal slices. The bottom slice is one ripple chain fed by the real incoming
carry. Every slice above it holds two ripple chains, one assuming an incoming
carry of 0 and one assuming 1. The true carry leaving the slice below then
picks one of the two results, both the slice's sum bits and its carry.

The worst-case path is one slice of ripple plus one 2:1 selection for each
slice boundary, rather than a ripple across the whole word. A single control
pin chooses between addition and subtraction. Subtraction forms a minus b by
inverting b and forcing the carry into the bottom slice high, so the external
carry is not used in that mode. `WIDTH` must be a whole multiple of `SEG_W`.
Any other pair of values stops elaboration with an error.

Top module: `csa_adder`

## Requirements
- R1: With `sub_mode`=0, `{carry_out, result}` equals `opnd_a + opnd_b + carry_in`, taken as a WIDTH+1 bit unsigned value.
- R2: With `sub_mode`=1, `result` equals `opnd_a - opnd_b` modulo 2^WIDTH, and `carry_in` has no effect on either output.
- R3: With `sub_mode`=1, `carry_out` is 1 exactly when `opnd_a` >= `opnd_b` as unsigned values, meaning no borrow, and 0 otherwise.
- R4: A carry produced in any bit propagates correctly across every slice boundary. Examples: adding 1 to a value whose k low bits are all ones yields 2^k, and `opnd_a` + ~`opnd_a` + `carry_in` yields all ones with `carry_out`=0 when `carry_in`=0, and all zeros with `carry_out`=1 when `carry_in`=1.
- R5: R1 to R3 hold for every legal pairing of `WIDTH` and `SEG_W`. This covers a single slice (`SEG_W`=`WIDTH`), odd slice widths, and four or more slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand (minuend when subtracting) |
| opnd_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Incoming carry, used only in add mode |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry selected for the top slice; in subtract mode 1 means no borrow |

## Verification
Four configurations are tried. An 8-bit, two-slice build and a 6-bit, single-slice build are swept over every operand, carry and mode combination. This separates mistakes in the select multiplexer from mistakes in the ripple chains. A 12-bit build with 3-bit slices and a 32-bit build with 8-bit slices receive walking all-ones runs plus 1, complement pairs, zero-minus-one and random operands. The runs of ones force carries across each slice boundary in turn. The random operands catch errors in slice indexing that the sweeps over small configurations would not show.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef struct packed {
    logic s;
    logic c;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
    fa_out_t r;
    r.s = x ^ y ^ ci;
    r.c = (x & y) | (ci & (x ^ y));
    return r;
  endfunction
endpackage

// File: rtl/csa_ripple_seg.sv
module csa_ripple_seg #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] seg_a,
  input  logic [SEG_W-1:0] seg_b,
  input  logic             seg_cin,
  output logic [SEG_W-1:0] seg_sum,
  output logic             seg_cout
);
  wire [SEG_W:0] chain;
  assign chain[0] = seg_cin;

  for (genvar i = 0; i < SEG_W; i++) begin : g_bit
    csa_pkg::fa_out_t fo;
    assign fo         = csa_pkg::full_add(seg_a[i], seg_b[i], chain[i]);
    assign seg_sum[i] = fo.s;
    assign chain[i+1] = fo.c;
  end

  assign seg_cout = chain[SEG_W];
endmodule

// File: rtl/csa_select_stage.sv
module csa_select_stage #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] st_a,
  input  logic [SEG_W-1:0] st_b,
  input  logic             st_sel,
  output logic [SEG_W-1:0] st_sum,
  output logic             st_cout
);
  logic [SEG_W-1:0] sum_c0, sum_c1;
  logic             cout_c0, cout_c1;

  csa_ripple_seg #(.SEG_W(SEG_W)) u_assume0 (
    .seg_a(st_a), .seg_b(st_b), .seg_cin(1'b0),
    .seg_sum(sum_c0), .seg_cout(cout_c0)
  );

  csa_ripple_seg #(.SEG_W(SEG_W)) u_assume1 (
    .seg_a(st_a), .seg_b(st_b), .seg_cin(1'b1),
    .seg_sum(sum_c1), .seg_cout(cout_c1)
  );

  always_comb begin
    if (st_sel) begin
      st_sum  = sum_c1;
      st_cout = cout_c1;
    end else begin
      st_sum  = sum_c0;
      st_cout = cout_c0;
    end
  end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int WIDTH = 16,
  parameter int SEG_W = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int N_SEG = WIDTH / SEG_W;

  if (SEG_W < 1 || WIDTH % SEG_W != 0) begin : g_bad_cfg
    $error("csa_adder: WIDTH must be a positive multiple of SEG_W");
  end

  // Subtract: invert b and force the bottom carry high (two's complement).
  wire [WIDTH-1:0] b_eff  = opnd_b ^ {WIDTH{sub_mode}};
  wire             c_base = sub_mode | carry_in;

  wire [N_SEG:0]   seg_c;
  wire [WIDTH-1:0] sum_w;
  assign seg_c[0] = c_base;

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    if (s == 0) begin : g_base
      csa_ripple_seg #(.SEG_W(SEG_W)) u_base (
        .seg_a   (opnd_a[0 +: SEG_W]),
        .seg_b   (b_eff[0 +: SEG_W]),
        .seg_cin (seg_c[0]),
        .seg_sum (sum_w[0 +: SEG_W]),
        .seg_cout(seg_c[1])
      );
    end else begin : g_spec
      csa_select_stage #(.SEG_W(SEG_W)) u_stage (
        .st_a   (opnd_a[s*SEG_W +: SEG_W]),
        .st_b   (b_eff[s*SEG_W +: SEG_W]),
        .st_sel (seg_c[s]),
        .st_sum (sum_w[s*SEG_W +: SEG_W]),
        .st_cout(seg_c[s+1])
      );
    end
  end

  assign result    = sum_w;
  assign carry_out = seg_c[N_SEG];
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
  parameter int WIDTH = 16,
  parameter int SEG_W = 4
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             carry_in,
  input logic             sub_mode,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  logic [WIDTH:0] add_ref;
  logic [WIDTH-1:0] diff_ref;
  logic [SEG_W:0] low_ref;
  logic [SEG_W-1:0] b_low;

  always_comb begin
    add_ref  = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
    diff_ref = opnd_a - opnd_b;
    b_low    = sub_mode ? ~opnd_b[SEG_W-1:0] : opnd_b[SEG_W-1:0];
    low_ref  = {1'b0, opnd_a[SEG_W-1:0]} + {1'b0, b_low}
             + {{SEG_W{1'b0}}, (sub_mode | carry_in)};
    if (!$isunknown({opnd_a, opnd_b, carry_in, sub_mode})) begin
      if (!sub_mode)
        p_add_total_r1: assert ({carry_out, result} == add_ref)
          else $error("R1 add mismatch");
      if (sub_mode)
        p_sub_diff_r2: assert (result == diff_ref)
          else $error("R2 difference mismatch");
      if (sub_mode)
        p_no_borrow_r3: assert (carry_out == (opnd_a >= opnd_b))
          else $error("R3 borrow flag mismatch");
      if (!sub_mode && opnd_b == ~opnd_a)
        p_full_chain_r4: assert (result == {WIDTH{~carry_in}} && carry_out == carry_in)
          else $error("R4 full propagate mismatch");
      p_base_slice_r5: assert (result[SEG_W-1:0] == low_ref[SEG_W-1:0])
        else $error("R5 bottom slice mismatch");
    end
  end
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .sub_mode(sub_mode),
  .result(result), .carry_out(carry_out)
);

// File: tb/csa_adder_test.sv
`timescale 1ns/1ps
module csa_adder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  // 8 bits, two 4-bit slices (exhaustive)
  logic [7:0] a8, b8, r8; logic ci8, sm8, co8;
  csa_adder #(.WIDTH(8), .SEG_W(4)) uut (
    .opnd_a(a8), .opnd_b(b8), .carry_in(ci8), .sub_mode(sm8), .result(r8), .carry_out(co8));

  // 6 bits, one slice (exhaustive)
  logic [5:0] a6, b6, r6; logic ci6, sm6, co6;
  csa_adder #(.WIDTH(6), .SEG_W(6)) uut_one (
    .opnd_a(a6), .opnd_b(b6), .carry_in(ci6), .sub_mode(sm6), .result(r6), .carry_out(co6));

  // 12 bits, four 3-bit slices
  logic [11:0] a12, b12, r12; logic ci12, sm12, co12;
  csa_adder #(.WIDTH(12), .SEG_W(3)) uut_odd (
    .opnd_a(a12), .opnd_b(b12), .carry_in(ci12), .sub_mode(sm12), .result(r12), .carry_out(co12));

  // 32 bits, four 8-bit slices
  logic [31:0] a32, b32, r32; logic ci32, sm32, co32;
  csa_adder #(.WIDTH(32), .SEG_W(8)) uut_wide (
    .opnd_a(a32), .opnd_b(b32), .carry_in(ci32), .sub_mode(sm32), .result(r32), .carry_out(co32));

  task automatic score(input string tag, input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected {carry, sum} from the requirements, for width w.
  function automatic longint unsigned expect_add(int w, longint unsigned a, longint unsigned b, bit ci);
    longint unsigned m = (64'd1 << (w + 1)) - 1;
    return (a + b + ci) & m;
  endfunction
  function automatic longint unsigned expect_diff(int w, longint unsigned a, longint unsigned b);
    longint unsigned m = (64'd1 << w) - 1;
    return (a - b) & m;
  endfunction

  task automatic run12(input logic [11:0] a, input logic [11:0] b, input bit ci, input bit sm, input string tag);
    a12 = a; b12 = b; ci12 = ci; sm12 = sm; #1;
    if (!sm) score({tag, " R1 w12"}, {co12, r12}, expect_add(12, a, b, ci));
    else begin
      score({tag, " R2 w12"}, r12, expect_diff(12, a, b));
      score({tag, " R3 w12"}, co12, (a >= b));
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input bit ci, input bit sm, input string tag);
    a32 = a; b32 = b; ci32 = ci; sm32 = sm; #1;
    if (!sm) score({tag, " R1 w32"}, {co32, r32}, expect_add(32, a, b, ci));
    else begin
      score({tag, " R2 w32"}, r32, expect_diff(32, a, b));
      score({tag, " R3 w32"}, co32, (a >= b));
    end
  endtask

  initial begin
    logic [7:0] keep_r; logic keep_c;
    a8 = 0; b8 = 0; ci8 = 0; sm8 = 0;
    a6 = 0; b6 = 0; ci6 = 0; sm6 = 0;
    a12 = 0; b12 = 0; ci12 = 0; sm12 = 0;
    a32 = 0; b32 = 0; ci32 = 0; sm32 = 0;
    #1;
    // Idle state: all-zero inputs give zero outputs (R1)
    score("R1 zero inputs", {co8, r8}, 0);
    score("R1 zero inputs w32", {co32, r32}, 0);

    // R1 R2 R3: exhaustive 8-bit, two slices
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int m = 0; m < 2; m++)
          for (int c = 0; c < 2; c++) begin
            a8 = 8'(a); b8 = 8'(b); sm8 = m[0]; ci8 = c[0]; #1;
            if (m == 0) score("R1 w8", {co8, r8}, expect_add(8, a, b, c[0]));
            else begin
              score("R2 w8", r8, expect_diff(8, a, b));
              score("R3 w8", co8, (a >= b));
            end
          end

    // R2: carry_in has no effect in subtract mode (outputs compared across both values)
    a8 = 8'h5A; b8 = 8'hC3; sm8 = 1; ci8 = 0; #1;
    keep_r = r8; keep_c = co8;
    ci8 = 1; #1;
    score("R2 carry_in ignored", {co8, r8}, {keep_c, keep_r});

    // R5: single slice, exhaustive
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        for (int m = 0; m < 2; m++)
          for (int c = 0; c < 2; c++) begin
            a6 = 6'(a); b6 = 6'(b); sm6 = m[0]; ci6 = c[0]; #1;
            if (m == 0) score("R5 R1 w6", {co6, r6}, expect_add(6, a, b, c[0]));
            else begin
              score("R5 R2 w6", r6, expect_diff(6, a, b));
              score("R5 R3 w6", co6, (a >= b));
            end
          end

    // R4: walking run of ones plus one crosses each boundary
    for (int k = 1; k <= 12; k++) run12(12'((1 << k) - 1), 12'd1, 0, 0, "R4 R5 walk");
    for (int k = 1; k <= 32; k++) run32(32'((64'd1 << k) - 1), 32'd1, 0, 0, "R4 walk");
    for (int k = 0; k < 32; k++) run32(32'((64'd1 << k) - 1), 32'd0, 1, 0, "R4 cin walk");
    // R4: complement pairs propagate end to end
    run32(32'h1234_5678, ~32'h1234_5678, 0, 0, "R4 complement c0");
    run32(32'h1234_5678, ~32'h1234_5678, 1, 0, "R4 complement c1");
    run12(12'hA5C, ~12'hA5C, 1, 0, "R4 R5 complement");
    run32(32'hFFFF_FFFF, 32'd0, 1, 0, "R4 all ones plus cin");
    run32(32'd0, 32'd1, 0, 1, "R3 zero minus one");
    run32(32'd7, 32'd7, 1, 1, "R3 equal operands");
    run12(12'd0, 12'hFFF, 0, 1, "R3 R5 max borrow");

    // R5: random operands on wide and odd-slice builds
    for (int i = 0; i < 3000; i++) begin
      run32($urandom, $urandom, 1'($urandom), 1'($urandom), "R5 rand");
      run12(12'($urandom), 12'($urandom), 1'($urandom), 1'($urandom), "R5 rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 150000) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule